// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a chip: a four-wire port (test clock, mode select, serial data in, serial data out) that walks the standard sixteen-state controller and routes the serial path through one of several shift registers. The instruction register is three bits wide. The data registers are a one-bit bypass stage, a 32-bit identification register, and a boundary register whose length and number of pin-backed cells are parameters.

The decoded instruction produces two controls for the pad ring. One hands the pins over to the boundary register's parallel update stage. The other forces every functional output to high impedance. The pad cells themselves are not part of the block; it only supplies captured values, update values and the two controls.

The block has no dedicated test reset pin. It returns to its reset state from the chip's power-on reset (`rst`, synchronous, active high, sampled on the rising test clock) or from five rising test-clock edges with mode select held high. Mode select and serial input are sampled on rising edges, and serial output moves on falling edges.

Top module: `scan_tap`

## Requirements
- R1: While `rst` is high at a rising `tck` edge, the controller goes to Test-Logic-Reset and the active instruction becomes identification (001). After that edge `tdo_en`, `tdo`, `ext_sel` and `out_hiz` read 0, and the update stage `bsr_out` reads all zeros.
- R2: `tms` is sampled on rising `tck` and steers the standard sixteen-state controller. Five consecutive rising edges with `tms` high reach Test-Logic-Reset from any state, and that reloads the identification instruction.
- R3: Capture-IR loads 001 into the instruction shift stage (the two low bits are 01, the top bit is 0). Shift-IR moves it out least-significant bit first, and `tdi` enters at the top bit.
- R4: The active instruction changes only on the rising edge that enters Update-IR. Through Shift-IR and the exit states, `ext_sel` and `out_hiz` keep the values of the previous instruction.
- R5: Decode of the active instruction: 000 selects the boundary register and sets `ext_sel`=1, `out_hiz`=0; 001 selects identification; 010 selects the boundary register and sets `out_hiz`=1, `ext_sel`=0; 100 selects the boundary register with both controls 0; 111 and the unused codes 011, 101, 110 select bypass with both controls 0.
- R6: The bypass stage captures 0 in Capture-DR. In Shift-DR it delays `tdi` by exactly one shift.
- R7: The identification register captures the `ID_CODE` parameter with bit 0 forced to 1 and shifts out 32 bits least-significant bit first.
- R8: In Capture-DR with the boundary register selected, cell i captures `pin_in[i]` for i < `BSR_PINS` and captures 1 for the cells above. Cell 0 drives the serial output and `tdi` enters at cell `BSR_LEN-1`.
- R9: `bsr_out` loads the boundary shift stage only on the rising edge that enters Update-DR while the boundary register is selected. Capturing and shifting leave it unchanged.
- R10: `tdo` and `tdo_en` change on falling `tck` edges. `tdo_en` is 1 only while the controller is in Shift-IR or Shift-DR, and `tdo` is 0 whenever `tdo_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst | input | 1 | Power-on reset, synchronous to rising `tck`, active high |
| tms | input | 1 | Mode select, steers the controller |
| tdi | input | 1 | Serial data in |
| pin_in | input | BSR_PINS | Pin values seen by the pin-backed boundary cells |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_en | output | 1 | Output enable for `tdo` |
| ext_sel | output | 1 | Pads take their values from `bsr_out` |
| out_hiz | output | 1 | Pads force their outputs to high impedance |
| bsr_out | output | BSR_LEN | Boundary register parallel update stage |

## Verification
The bench shifts an instruction into the controller and checks the decoded controls in the exit state before Update-IR. A design that acts on instructions while they are still shifting would change `out_hiz` one state too early. Every unused code is loaded and run through a bypass shift, so a decode that lets a reserved value fall through to identification or boundary selection would show the wrong serial stream. It preloads the boundary register twice and checks `bsr_out` on every shift cycle, which catches an update stage that follows the shift chain. It also walks from Pause-DR with `tms` high and checks that the controls survive four edges and clear on the fifth, and it samples `tdo_en` just after the rising edge that enters Shift-DR, before the falling edge, to catch an output that moves on the wrong edge.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

    localparam int IR_W = 3;
    localparam int ID_W = 32;

    typedef logic [IR_W-1:0] opcode_t;

    localparam opcode_t OP_EXT_TEST = 3'b000;
    localparam opcode_t OP_IDENT    = 3'b001;
    localparam opcode_t OP_SAMPLE_Z = 3'b010;
    localparam opcode_t OP_SAMPLE   = 3'b100;
    localparam opcode_t OP_BYPASS   = 3'b111;

    // Pattern loaded into the instruction shift stage in Capture-IR.
    localparam opcode_t IR_CAPTURE  = {{(IR_W-2){1'b0}}, 2'b01};

    typedef enum logic [3:0] {
        TS_RESET,
        TS_IDLE,
        TS_DR_SEL,
        TS_DR_CAP,
        TS_DR_SHIFT,
        TS_DR_EXIT1,
        TS_DR_PAUSE,
        TS_DR_EXIT2,
        TS_DR_UPD,
        TS_IR_SEL,
        TS_IR_CAP,
        TS_IR_SHIFT,
        TS_IR_EXIT1,
        TS_IR_PAUSE,
        TS_IR_EXIT2,
        TS_IR_UPD
    } tap_state_e;

    typedef enum logic [1:0] {
        DR_BYPASS,
        DR_IDENT,
        DR_BOUNDARY
    } dr_sel_e;

    typedef struct packed {
        dr_sel_e sel;
        logic    ext_drive;
        logic    force_z;
    } op_decode_t;

    function automatic tap_state_e tap_next(tap_state_e s, logic m);
        tap_state_e n;
        case (s)
            TS_RESET:    n = m ? TS_RESET    : TS_IDLE;
            TS_IDLE:     n = m ? TS_DR_SEL   : TS_IDLE;
            TS_DR_SEL:   n = m ? TS_IR_SEL   : TS_DR_CAP;
            TS_DR_CAP:   n = m ? TS_DR_EXIT1 : TS_DR_SHIFT;
            TS_DR_SHIFT: n = m ? TS_DR_EXIT1 : TS_DR_SHIFT;
            TS_DR_EXIT1: n = m ? TS_DR_UPD   : TS_DR_PAUSE;
            TS_DR_PAUSE: n = m ? TS_DR_EXIT2 : TS_DR_PAUSE;
            TS_DR_EXIT2: n = m ? TS_DR_UPD   : TS_DR_SHIFT;
            TS_DR_UPD:   n = m ? TS_DR_SEL   : TS_IDLE;
            TS_IR_SEL:   n = m ? TS_RESET    : TS_IR_CAP;
            TS_IR_CAP:   n = m ? TS_IR_EXIT1 : TS_IR_SHIFT;
            TS_IR_SHIFT: n = m ? TS_IR_EXIT1 : TS_IR_SHIFT;
            TS_IR_EXIT1: n = m ? TS_IR_UPD   : TS_IR_PAUSE;
            TS_IR_PAUSE: n = m ? TS_IR_EXIT2 : TS_IR_PAUSE;
            TS_IR_EXIT2: n = m ? TS_IR_UPD   : TS_IR_SHIFT;
            TS_IR_UPD:   n = m ? TS_DR_SEL   : TS_IDLE;
            default:     n = TS_RESET;
        endcase
        return n;
    endfunction

    function automatic op_decode_t op_decode(opcode_t op);
        op_decode_t d;
        d.sel       = DR_BYPASS;
        d.ext_drive = 1'b0;
        d.force_z   = 1'b0;
        case (op)
            OP_EXT_TEST: begin d.sel = DR_BOUNDARY; d.ext_drive = 1'b1; end
            OP_IDENT:    d.sel = DR_IDENT;
            OP_SAMPLE_Z: begin d.sel = DR_BOUNDARY; d.force_z = 1'b1; end
            OP_SAMPLE:   d.sel = DR_BOUNDARY;
            default:     d.sel = DR_BYPASS;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state,
    output tap_state_e state_nx
);

    assign state_nx = tap_next(state, tms);

    always_ff @(posedge tck) begin
        if (rst) state <= TS_RESET;
        else     state <= state_nx;
    end

    // Run of consecutive high mode-select samples, saturating at five.
    logic [2:0] high_run;
    always_ff @(posedge tck) begin
        if (rst)       high_run <= 3'd0;
        else if (!tms) high_run <= 3'd0;
        else if (high_run != 3'd5) high_run <= high_run + 3'd1;
    end

    p_five_high_reset_r2: assert property (@(posedge tck) disable iff (rst)
        (tms && high_run >= 3'd4) |=> (state == TS_RESET));

endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tdi,
    input  tap_state_e state,
    input  tap_state_e state_nx,
    output opcode_t    op_active,
    output logic       ir_serial
);

    opcode_t ir_sr;

    always_ff @(posedge tck) begin
        if (rst) begin
            ir_sr <= IR_CAPTURE;
        end else if (state == TS_IR_CAP) begin
            ir_sr <= IR_CAPTURE;
        end else if (state == TS_IR_SHIFT) begin
            ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        end
    end

    always_ff @(posedge tck) begin
        if (rst || state_nx == TS_RESET) op_active <= OP_IDENT;
        else if (state_nx == TS_IR_UPD)  op_active <= ir_sr;
    end

    assign ir_serial = ir_sr[0];

    p_capture_pattern_r3: assert property (@(posedge tck) disable iff (rst)
        (state == TS_IR_CAP) |=> (ir_sr[1:0] == 2'b01));

    p_op_hold_r4: assert property (@(posedge tck) disable iff (rst)
        (state_nx != TS_IR_UPD && state_nx != TS_RESET) |=> $stable(op_active));

    p_reset_ident_r1: assert property (@(posedge tck) disable iff (rst)
        (state == TS_RESET) |-> (op_active == OP_IDENT));

endmodule

// File: rtl/scan_tap_dr.sv
module scan_tap_dr
    import scan_tap_pkg::*;
#(
    parameter int unsigned       BSR_LEN  = 8,
    parameter int unsigned       BSR_PINS = 6,
    parameter logic [ID_W-1:0]   ID_CODE  = 32'h1C3A_5E06
) (
    input  logic                tck,
    input  logic                rst,
    input  logic                tdi,
    input  tap_state_e          state,
    input  tap_state_e          state_nx,
    input  dr_sel_e             sel,
    input  logic [BSR_PINS-1:0] pin_in,
    output logic [BSR_LEN-1:0]  bsr_upd,
    output logic                dr_serial
);

    localparam logic [ID_W-1:0] ID_VALUE = {ID_CODE[ID_W-1:1], 1'b1};

    logic                byp_q;
    logic [ID_W-1:0]     id_sr;
    logic [BSR_LEN-1:0]  bsr_sr;
    logic [BSR_LEN-1:0]  cap_vec;

    for (genvar g = 0; g < BSR_LEN; g++) begin : g_cell
        if (g < BSR_PINS) begin : g_pin
            assign cap_vec[g] = pin_in[g];
        end else begin : g_tie
            assign cap_vec[g] = 1'b1;
        end
    end

    always_ff @(posedge tck) begin
        if (rst) begin
            byp_q  <= 1'b0;
            id_sr  <= ID_VALUE;
            bsr_sr <= '0;
        end else if (state == TS_DR_CAP) begin
            case (sel)
                DR_IDENT:    id_sr  <= ID_VALUE;
                DR_BOUNDARY: bsr_sr <= cap_vec;
                default:     byp_q  <= 1'b0;
            endcase
        end else if (state == TS_DR_SHIFT) begin
            case (sel)
                DR_IDENT:    id_sr  <= {tdi, id_sr[ID_W-1:1]};
                DR_BOUNDARY: bsr_sr <= {tdi, bsr_sr[BSR_LEN-1:1]};
                default:     byp_q  <= tdi;
            endcase
        end
    end

    always_ff @(posedge tck) begin
        if (rst)                                          bsr_upd <= '0;
        else if (state_nx == TS_DR_UPD && sel == DR_BOUNDARY) bsr_upd <= bsr_sr;
    end

    always_comb begin
        case (sel)
            DR_IDENT:    dr_serial = id_sr[0];
            DR_BOUNDARY: dr_serial = bsr_sr[0];
            default:     dr_serial = byp_q;
        endcase
    end

    p_update_only_r9: assert property (@(posedge tck) disable iff (rst)
        !(state_nx == TS_DR_UPD && sel == DR_BOUNDARY) |=> $stable(bsr_upd));

    p_bypass_zero_r6: assert property (@(posedge tck) disable iff (rst)
        (state == TS_DR_CAP && sel == DR_BYPASS) |=> (byp_q == 1'b0));

endmodule

// File: rtl/scan_tap.sv
module scan_tap
    import scan_tap_pkg::*;
#(
    parameter int unsigned     BSR_LEN  = 8,
    parameter int unsigned     BSR_PINS = 6,
    parameter logic [31:0]     ID_CODE  = 32'h1C3A_5E06
) (
    input  logic                tck,
    input  logic                rst,
    input  logic                tms,
    input  logic                tdi,
    input  logic [BSR_PINS-1:0] pin_in,
    output logic                tdo,
    output logic                tdo_en,
    output logic                ext_sel,
    output logic                out_hiz,
    output logic [BSR_LEN-1:0]  bsr_out
);

    tap_state_e state;
    tap_state_e state_nx;
    opcode_t    op_active;
    op_decode_t dec;
    logic       ir_serial;
    logic       dr_serial;
    logic       in_shift;
    logic       serial_src;

    scan_tap_fsm u_fsm (
        .tck      (tck),
        .rst      (rst),
        .tms      (tms),
        .state    (state),
        .state_nx (state_nx)
    );

    scan_tap_ir u_ir (
        .tck       (tck),
        .rst       (rst),
        .tdi       (tdi),
        .state     (state),
        .state_nx  (state_nx),
        .op_active (op_active),
        .ir_serial (ir_serial)
    );

    assign dec = op_decode(op_active);

    scan_tap_dr #(
        .BSR_LEN  (BSR_LEN),
        .BSR_PINS (BSR_PINS),
        .ID_CODE  (ID_CODE)
    ) u_dr (
        .tck       (tck),
        .rst       (rst),
        .tdi       (tdi),
        .state     (state),
        .state_nx  (state_nx),
        .sel       (dec.sel),
        .pin_in    (pin_in),
        .bsr_upd   (bsr_out),
        .dr_serial (dr_serial)
    );

    assign in_shift   = (state == TS_IR_SHIFT) || (state == TS_DR_SHIFT);
    assign serial_src = (state == TS_IR_SHIFT) ? ir_serial : dr_serial;

    // Serial output is retimed to the falling edge.
    always_ff @(negedge tck) begin
        if (rst) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo    <= in_shift & serial_src;
            tdo_en <= in_shift;
        end
    end

    assign ext_sel = dec.ext_drive;
    assign out_hiz = dec.force_z;

    p_controls_exclusive_r5: assert property (@(posedge tck) disable iff (rst)
        !(ext_sel && out_hiz));

endmodule

// File: tb/scan_tap_bench.sv
module scan_tap_bench;

    localparam int unsigned LEN  = 12;
    localparam int unsigned PINS = 7;
    localparam logic [31:0] IDC  = 32'h2B6D_9E40;
    localparam logic [31:0] IDX  = 32'h2B6D_9E41;

    localparam int K_TDO = 0;
    localparam int K_EN  = 1;
    localparam int K_EXT = 2;
    localparam int K_HIZ = 3;
    localparam int K_BSR = 4;

    logic            tck = 1'b0;
    logic            rst = 1'b1;
    logic            tms = 1'b1;
    logic            tdi = 1'b1;
    logic [PINS-1:0] pin_in = '0;
    logic            tdo, tdo_en, ext_sel, out_hiz;
    logic [LEN-1:0]  bsr_out;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];

    scan_tap #(.BSR_LEN(LEN), .BSR_PINS(PINS), .ID_CODE(IDC)) u_scan_tap (
        .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .pin_in(pin_in),
        .tdo(tdo), .tdo_en(tdo_en), .ext_sel(ext_sel), .out_hiz(out_hiz),
        .bsr_out(bsr_out)
    );

    initial forever #4 tck = ~tck;

    function automatic logic [31:0] observe(int k);
        case (k)
            K_TDO:   return {31'd0, tdo};
            K_EN:    return {31'd0, tdo_en};
            K_EXT:   return {31'd0, ext_sel};
            K_HIZ:   return {31'd0, out_hiz};
            default: return {{(32-LEN){1'b0}}, bsr_out};
        endcase
    endfunction

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // Monitor: compares pending expectations after each falling edge.
    initial forever begin
        @(negedge tck);
        #1;
        while (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check(observe(it.kind), it.exp, it.tag);
        end
    end

    task automatic expect_now(input int k, input logic [31:0] v, input string tag);
        item_t it;
        it.kind = k; it.exp = v; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic step(input logic m, input logic d);
        tms = m;
        tdi = d;
        @(posedge tck);
        #2;
    endtask

    // From Run-Test/Idle: load an instruction, ending back in Run-Test/Idle.
    task automatic load_ir(input logic [2:0] op);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 3; i++) begin
            expect_now(K_TDO, {31'd0, (i == 0)}, "R3 capture pattern");
            expect_now(K_EN, 32'd1, "R10 enable in shift-ir");
            step(i == 2, op[i]);
        end
        step(1, 0);
        step(0, 0);
        expect_now(K_EN, 32'd0, "R10 enable off in idle");
        expect_now(K_TDO, 32'd0, "R10 quiet tdo in idle");
    endtask

    // From Run-Test/Idle: capture, shift n bits, update, back to idle.
    task automatic shift_dr(input int n, input logic [31:0] din, input logic [31:0] exp,
                            input string tag, input bit hold_chk, input logic [31:0] hold_v);
        step(1, 0); step(0, 0); step(0, 0);
        check({31'd0, tdo_en}, 32'd0, "R10 enable waits for falling edge");
        for (int i = 0; i < n; i++) begin
            expect_now(K_TDO, {31'd0, exp[i]}, tag);
            if (hold_chk) expect_now(K_BSR, hold_v, "R9 update stage holds while shifting");
            step(i == n - 1, din[i]);
        end
        step(1, 0);
        step(0, 0);
    endtask

    initial begin
        repeat (3) @(posedge tck);
        #2;
        rst = 1'b0;
        expect_now(K_EN,  32'd0, "R1 tdo_en after reset");
        expect_now(K_TDO, 32'd0, "R1 tdo after reset");
        expect_now(K_EXT, 32'd0, "R1 ext_sel after reset");
        expect_now(K_HIZ, 32'd0, "R1 out_hiz after reset");
        expect_now(K_BSR, 32'd0, "R1 bsr_out after reset");
        step(0, 0);

        // R7 / R1: identification is the default instruction.
        shift_dr(32, 32'h0, IDX, "R7 identification stream", 1'b0, 32'd0);

        // R6: bypass delays tdi by one stage, capturing 0 first.
        load_ir(3'b111);
        shift_dr(8, 32'h0000_00B5, {24'd0, 8'h6A}, "R6 bypass delay", 1'b0, 32'd0);

        // R5: reserved codes fall back to bypass.
        foreach (ResCodes[j]) begin
            load_ir(ResCodes[j]);
            expect_now(K_EXT, 32'd0, "R5 reserved ext_sel");
            expect_now(K_HIZ, 32'd0, "R5 reserved out_hiz");
            shift_dr(6, 32'h0000_002D, {26'd0, 6'h1A}, "R5 reserved acts as bypass", 1'b0, 32'd0);
        end

        // R4: instruction 010 takes effect only on entering Update-IR.
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        step(0, 0); step(0, 1); step(1, 0);
        expect_now(K_HIZ, 32'd0, "R4 no effect in exit state");
        step(1, 0);
        expect_now(K_HIZ, 32'd1, "R4 effect after update");
        expect_now(K_EXT, 32'd0, "R5 sample-z ext_sel");
        step(0, 0);

        // R8: boundary capture with tied cells, under sample-z.
        pin_in = 7'b0101101;
        shift_dr(LEN, 32'h0, 32'h0000_0FAD, "R8 capture sample-z", 1'b0, 32'd0);

        // R5 / R8 / R9: sample/preload.
        load_ir(3'b100);
        expect_now(K_EXT, 32'd0, "R5 sample ext_sel");
        expect_now(K_HIZ, 32'd0, "R5 sample out_hiz");
        pin_in = 7'b1010010;
        shift_dr(LEN, 32'h0000_0A5C, 32'h0000_0FD2, "R8 capture sample", 1'b0, 32'd0);
        expect_now(K_BSR, 32'h0000_0A5C, "R9 preload value");
        shift_dr(LEN, 32'h0000_03C3, 32'h0000_0FD2, "R8 capture sample again", 1'b1, 32'h0000_0A5C);
        expect_now(K_BSR, 32'h0000_03C3, "R9 second preload value");

        // R5: external test drives the pins.
        load_ir(3'b000);
        expect_now(K_EXT, 32'd1, "R5 ext-test ext_sel");
        expect_now(K_HIZ, 32'd0, "R5 ext-test out_hiz");
        expect_now(K_BSR, 32'h0000_03C3, "R9 unchanged by instruction load");
        step(0, 0);

        // R2: five high mode-select edges from Pause-DR.
        step(1, 0); step(0, 0); step(1, 0); step(0, 0);
        for (int i = 0; i < 4; i++) step(1, 0);
        expect_now(K_EXT, 32'd1, "R2 four highs not enough");
        step(1, 0);
        expect_now(K_EXT, 32'd0, "R2 five highs reach reset");
        step(0, 0);
        shift_dr(32, 32'h0, IDX, "R2 identification reloaded", 1'b0, 32'd0);

        // R1: power-on reset mid-operation.
        load_ir(3'b000);
        expect_now(K_EXT, 32'd1, "R5 ext-test before reset");
        step(0, 0);
        rst = 1'b1;
        step(0, 0);
        rst = 1'b0;
        expect_now(K_EXT, 32'd0, "R1 reset clears instruction");
        expect_now(K_BSR, 32'd0, "R1 reset clears update stage");
        step(0, 0);

        @(negedge tck);
        #3;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    localparam logic [2:0] ResCodes [3] = '{3'b011, 3'b101, 3'b110};

    initial begin
        repeat (20000) @(posedge tck);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule